// File: doc/BRIEF.md
# Descriptor command queue controller

This block runs one hardware command queue. Software places 32-byte command descriptors in a ring held in memory, then moves a tail pointer forward through a small register file. While the queue is enabled, the block does the following for each descriptor:

- It reads word 0 of the descriptor at the head pointer over a synchronous read port.
- It decodes the command fields of that word.
- It offers the command to an engine over a valid/ready handshake.
- It waits for the engine to report done or error.

When a descriptor retires without error, the head pointer moves forward one slot and wraps inside the ring. The block can raise a completion interrupt, and it can stop itself, as each descriptor asks.

The ring holds a power-of-two number of slots set by a 5-bit size code. The ring must be aligned in memory to its own byte size. Head and tail are byte addresses that move in 32-byte steps. The queue is empty when head equals tail. Three sticky status causes feed one interrupt line through an enable mask: completion, error and stopped. Software clears a cause by writing 1 to its bit.

Top module: `cmdq_ctrl`

## Requirements
- R1: After reset the following all read 0: control, tail, head, interrupt enable and interrupt status. `irq` is 0, no descriptor read is issued, and queue status reads 1 (empty, idle).
- R2: The register offsets are: control 0x00, tail 0x04, head 0x08, interrupt enable 0x0C, interrupt status 0x10, queue status 0x100.
  - Control keeps bit 0 (run) and bits 7:3 (size code). All other control bits read 0.
  - Tail and head read back with bits 4:0 forced to 0.
  - Interrupt enable keeps bits 2:0.
- R3: A descriptor read (`dmem_rd`) is issued only while run is 1 and head differs from tail. There is exactly one read per descriptor, at the head address.
- R4: Word 0 is decoded as follows: bits 23:20 give `eng_sel`, bits 19:5 give `eng_func`, bit 3 gives `eng_init`, bit 4 gives `eng_eom` and bit 24 gives `eng_prot`. `eng_desc` carries the address of the descriptor.
- R5: Once `eng_valid` rises, it stays high with unchanged command fields until `eng_ready` is seen high.
- R6: On `eng_done` without `eng_err`, head advances by 32 bytes. A size code n gives a ring of 2^(n+1) slots. Head wraps to the ring base after the last slot.
- R7: A retired descriptor with word 0 bit 1 set sets interrupt status bit 0 (completion). Without that bit, the status is unchanged.
- R8: A retired descriptor with word 0 bit 0 set clears run and sets status bit 2 (stopped). Head still advances, and no further reads are issued.
- R9: `eng_err` clears run and sets status bits 1 (error) and 2 (stopped). Head stays on the failing descriptor.
- R10: An engine select whose bit in ENGINE_MASK is 0 is an error. It has the same effect as R9, and `eng_valid` is never raised for that descriptor. The default mask attaches values 0 to 7.
- R11: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. `irq` is the OR over the three bits of status ANDed with enable.
- R12: Queue status bit 0 is 1 when head equals tail. Bit 1 is 1 while a descriptor is being fetched, issued or executed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | RA_W | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| dmem_rd | output | 1 | Descriptor word read request |
| dmem_addr | output | PTR_W | Byte address of the word read |
| dmem_rdata | input | 32 | Read data, valid one cycle after dmem_rd |
| eng_valid | output | 1 | Command offered to the engine |
| eng_ready | input | 1 | Engine accepts the command |
| eng_sel | output | 4 | Engine select |
| eng_func | output | 15 | Function field |
| eng_init | output | 1 | Init flag |
| eng_eom | output | 1 | End-of-message flag |
| eng_prot | output | 1 | Protection flag |
| eng_desc | output | PTR_W | Address of the current descriptor |
| eng_done | input | 1 | Engine finished the accepted command |
| eng_err | input | 1 | Engine reports failure (qualifies eng_done or stands alone) |
| irq | output | 1 | Interrupt request |

## Verification
Register writes take effect at the edge that closes the write cycle. Reads are combinational, so the bench reads them in the next low phase.

The first read of a descriptor comes in the cycle after the tail or run write lands. `eng_valid` follows two edges later: one for the memory latency and one for decode. Head, status, run and `irq` change at the edge that samples `eng_done`, or at the decode edge for a rejected engine select.

The bench's engine model and register tasks act only on falling edges. Each check is placed at least one full cycle past the edge that produces its result. Counters driven by the rising edge show that no descriptor read and no valid appear where none are due.

// File: rtl/cmdq_ctrl.sv
module cmdq_ctrl #(
  parameter int          PTR_W       = 32,
  parameter int          RA_W        = 9,
  parameter logic [15:0] ENGINE_MASK = 16'h00FF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [RA_W-1:0]  reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  output logic             dmem_rd,
  output logic [PTR_W-1:0] dmem_addr,
  input  logic [31:0]      dmem_rdata,
  output logic             eng_valid,
  input  logic             eng_ready,
  output logic [3:0]       eng_sel,
  output logic [14:0]      eng_func,
  output logic             eng_init,
  output logic             eng_eom,
  output logic             eng_prot,
  output logic [PTR_W-1:0] eng_desc,
  input  logic             eng_done,
  input  logic             eng_err,
  output logic             irq
);

  localparam logic [RA_W-1:0] A_CTRL = RA_W'('h000);
  localparam logic [RA_W-1:0] A_TAIL = RA_W'('h004);
  localparam logic [RA_W-1:0] A_HEAD = RA_W'('h008);
  localparam logic [RA_W-1:0] A_IEN  = RA_W'('h00C);
  localparam logic [RA_W-1:0] A_IST  = RA_W'('h010);
  localparam logic [RA_W-1:0] A_QST  = RA_W'('h100);
  localparam logic [PTR_W-1:0] SLOT  = PTR_W'(32);
  localparam logic [PTR_W-1:0] ALIGN = ~PTR_W'(31);

  typedef enum logic [1:0] {S_IDLE, S_LATCH, S_ISSUE, S_BUSY} st_t;

  st_t              state;
  logic             run;
  logic [4:0]       sz;
  logic [PTR_W-1:0] tail, head;
  logic [2:0]       ien, ist;
  logic [31:0]      w0;

  logic [5:0]       sh;
  logic [PTR_W-1:0] wmask, head_nxt;
  logic             empty, bad_sel, hw_stop, retire;
  logic [2:0]       st_set, st_clr;

  assign sh       = {1'b0, sz} + 6'd6;
  assign wmask    = ~({PTR_W{1'b1}} << sh);
  assign head_nxt = (head & ~wmask) | ((head + SLOT) & wmask);
  assign empty    = (head == tail);
  assign bad_sel  = !ENGINE_MASK[dmem_rdata[23:20]];

  assign dmem_rd   = (state == S_IDLE) && run && !empty;
  assign dmem_addr = head;
  assign eng_valid = (state == S_ISSUE);
  assign eng_sel   = w0[23:20];
  assign eng_func  = w0[19:5];
  assign eng_init  = w0[3];
  assign eng_eom   = w0[4];
  assign eng_prot  = w0[24];
  assign eng_desc  = head;
  assign irq       = |(ist & ien);
  assign st_clr    = (reg_we && reg_addr == A_IST) ? reg_wdata[2:0] : 3'b000;

  always_comb begin
    st_set  = 3'b000;
    hw_stop = 1'b0;
    retire  = 1'b0;
    if (state == S_LATCH && bad_sel) begin
      st_set  = 3'b110;
      hw_stop = 1'b1;
    end else if (state == S_BUSY && eng_err) begin
      st_set  = 3'b110;
      hw_stop = 1'b1;
    end else if (state == S_BUSY && eng_done) begin
      retire  = 1'b1;
      st_set  = {w0[0], 1'b0, w0[1]};
      hw_stop = w0[0];
    end
  end

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = {24'b0, sz, 2'b0, run};
      A_TAIL:  reg_rdata = 32'(tail);
      A_HEAD:  reg_rdata = 32'(head);
      A_IEN:   reg_rdata = {29'b0, ien};
      A_IST:   reg_rdata = {29'b0, ist};
      A_QST:   reg_rdata = {30'b0, state != S_IDLE, empty};
      default: reg_rdata = 32'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      run   <= 1'b0;
      sz    <= '0;
      tail  <= '0;
      head  <= '0;
      ien   <= '0;
      ist   <= '0;
      w0    <= '0;
    end else begin
      if (reg_we && reg_addr == A_CTRL) begin
        run <= reg_wdata[0];
        sz  <= reg_wdata[7:3];
      end
      if (hw_stop) run <= 1'b0;
      if (reg_we && reg_addr == A_TAIL) tail <= reg_wdata[PTR_W-1:0] & ALIGN;
      if (reg_we && reg_addr == A_HEAD) head <= reg_wdata[PTR_W-1:0] & ALIGN;
      if (retire) head <= head_nxt;
      if (reg_we && reg_addr == A_IEN) ien <= reg_wdata[2:0];
      ist <= (ist & ~st_clr) | st_set;
      case (state)
        S_IDLE:  if (dmem_rd) state <= S_LATCH;
        S_LATCH: begin
          w0    <= dmem_rdata;
          state <= bad_sel ? S_IDLE : S_ISSUE;
        end
        S_ISSUE: if (eng_ready) state <= S_BUSY;
        S_BUSY:  if (eng_done || eng_err) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  p_one_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_rd |=> !dmem_rd);

  p_valid_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    eng_valid && !eng_ready |=> eng_valid && $stable(eng_sel) && $stable(eng_func) && $stable(eng_desc));

  p_head_moves_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_BUSY) && eng_done && !eng_err |=> head != $past(head));

  p_err_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_BUSY) && eng_err |=> !run && ist[1] && ist[2]);

  p_err_head_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_BUSY) && eng_err && !reg_we |=> $stable(head));

  p_attached_r10: assert property (@(posedge clk) disable iff (!rst_n)
    eng_valid |-> ENGINE_MASK[eng_sel]);

endmodule

// File: tb/cmdq_ctrl_bench.sv
module cmdq_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [8:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        dmem_rd;
  logic [31:0] dmem_addr;
  logic [31:0] dmem_rdata = '0;
  logic        eng_valid;
  logic        eng_ready = 1'b0;
  logic [3:0]  eng_sel;
  logic [14:0] eng_func;
  logic        eng_init, eng_eom, eng_prot;
  logic [31:0] eng_desc;
  logic        eng_done = 1'b0;
  logic        eng_err = 1'b0;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  int fetches = 0;
  int valids  = 0;
  logic [31:0] mem [256];

  always #4 clk = ~clk;

  cmdq_ctrl u_cmdq_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dmem_rd(dmem_rd),
    .dmem_addr(dmem_addr), .dmem_rdata(dmem_rdata), .eng_valid(eng_valid),
    .eng_ready(eng_ready), .eng_sel(eng_sel), .eng_func(eng_func),
    .eng_init(eng_init), .eng_eom(eng_eom), .eng_prot(eng_prot),
    .eng_desc(eng_desc), .eng_done(eng_done), .eng_err(eng_err), .irq(irq));

  always @(posedge clk) begin
    if (dmem_rd) begin
      dmem_rdata <= mem[dmem_addr[9:2]];
      fetches <= fetches + 1;
    end
    if (eng_valid) valids <= valids + 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [8:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  function automatic logic [31:0] w0(input logic [3:0] sel, input logic soc, input logic ioc);
    return {8'h00, sel, 15'h0, 3'b000, ioc, soc};
  endfunction

  task automatic wait_valid(input string req);
    for (int i = 0; i < 40; i++) begin
      if (eng_valid) break;
      @(negedge clk);
    end
    chk(req, {31'b0, eng_valid}, 32'd1);
  endtask

  task automatic finish_cmd(input logic err);
    eng_ready = 1'b1;
    @(negedge clk);
    eng_ready = 1'b0;
    repeat (2) @(negedge clk);
    eng_done = 1'b1; eng_err = err;
    @(negedge clk);
    eng_done = 1'b0; eng_err = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(9'h000, d); chk("R1 ctrl", d, 0);
    rd(9'h004, d); chk("R1 tail", d, 0);
    rd(9'h008, d); chk("R1 head", d, 0);
    rd(9'h00C, d); chk("R1 ien", d, 0);
    rd(9'h010, d); chk("R1 ist", d, 0);
    rd(9'h100, d); chk("R1 qst", d, 1);
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 no read", {31'b0, dmem_rd}, 0);
  endtask

  task automatic t_regs;
    logic [31:0] d;
    wr(9'h000, 32'hFFFF_FFFE); rd(9'h000, d); chk("R2 ctrl fields", d, 32'hF8);
    wr(9'h004, 32'h0000_013F); rd(9'h004, d); chk("R2 tail align", d, 32'h120);
    wr(9'h008, 32'h0000_0127); rd(9'h008, d); chk("R2 head align", d, 32'h120);
    wr(9'h00C, 32'hFFFF_FFFF); rd(9'h00C, d); chk("R2 ien bits", d, 7);
    wr(9'h00C, 0); wr(9'h004, 0); wr(9'h008, 0); wr(9'h000, 32'h08);
    rd(9'h000, d); chk("R2 ctrl size 1 run 0", d, 32'h08);
  endtask

  task automatic t_no_run;
    logic [31:0] d;
    mem[0] = w0(4'd5, 1'b0, 1'b1) | 32'h0102_469A;
    wr(9'h004, 32'd32);
    repeat (8) @(negedge clk);
    chk("R3 no read while stopped", fetches, 0);
    rd(9'h100, d); chk("R12 not empty idle", d, 0);
  endtask

  task automatic t_basic;
    logic [31:0] d;
    int f0;
    f0 = fetches;
    wr(9'h00C, 32'd1);
    wr(9'h000, 32'h09);
    wait_valid("R3 descriptor issued");
    chk("R3 one read", fetches - f0, 1);
    chk("R4 sel", {28'b0, eng_sel}, 5);
    chk("R4 func", {17'b0, eng_func}, 32'h1234);
    chk("R4 init eom prot", {29'b0, eng_init, eng_eom, eng_prot}, 7);
    chk("R4 desc addr", eng_desc, 0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R5 valid held", {27'b0, eng_valid, eng_sel}, 32'h15);
    end
    rd(9'h100, d); chk("R12 busy", d, 2);
    finish_cmd(1'b0);
    rd(9'h008, d); chk("R6 head step", d, 32);
    rd(9'h010, d); chk("R7 completion", d, 1);
    chk("R11 irq on", {31'b0, irq}, 1);
    rd(9'h100, d); chk("R12 empty idle", d, 1);
    wr(9'h010, 32'd6); rd(9'h010, d); chk("R11 write 0 keeps", d, 1);
    wr(9'h010, 32'd1); rd(9'h010, d); chk("R11 w1c", d, 0);
    chk("R11 irq off", {31'b0, irq}, 0);
  endtask

  task automatic t_wrap;
    logic [31:0] d;
    mem[8]  = w0(4'd3, 1'b0, 1'b0);
    mem[16] = w0(4'd1, 1'b0, 1'b0);
    mem[24] = w0(4'd7, 1'b0, 1'b0);
    wr(9'h004, 32'd0);
    wait_valid("R6 slot1"); chk("R4 desc slot1", eng_desc, 32);
    finish_cmd(1'b0);
    rd(9'h010, d); chk("R7 no ioc no status", d, 0);
    wait_valid("R6 slot2"); chk("R4 sel slot2", {28'b0, eng_sel}, 1);
    finish_cmd(1'b0);
    wait_valid("R6 slot3"); chk("R4 desc slot3", eng_desc, 96);
    finish_cmd(1'b0);
    rd(9'h008, d); chk("R6 wrap to base", d, 0);
  endtask

  task automatic t_soc;
    logic [31:0] d;
    int f0;
    mem[0] = w0(4'd0, 1'b1, 1'b0);
    mem[8] = w0(4'd2, 1'b0, 1'b0);
    wr(9'h00C, 0);
    wr(9'h004, 32'd32);
    wait_valid("R8 issue");
    finish_cmd(1'b0);
    rd(9'h008, d); chk("R8 head advanced", d, 32);
    rd(9'h000, d); chk("R8 run cleared", d, 32'h08);
    rd(9'h010, d); chk("R8 stopped", d, 4);
    wr(9'h010, 32'd7);
    f0 = fetches;
    wr(9'h004, 32'd64);
    repeat (6) @(negedge clk);
    chk("R8 no read after stop", fetches - f0, 0);
  endtask

  task automatic t_err;
    logic [31:0] d;
    wr(9'h000, 32'h09);
    wait_valid("R9 issue");
    finish_cmd(1'b1);
    rd(9'h008, d); chk("R9 head held", d, 32);
    rd(9'h000, d); chk("R9 run cleared", d, 32'h08);
    rd(9'h010, d); chk("R9 err and stopped", d, 6);
    chk("R11 masked irq", {31'b0, irq}, 0);
    wr(9'h00C, 32'd2);
    chk("R11 enabled irq", {31'b0, irq}, 1);
    wr(9'h010, 32'd6);
  endtask

  task automatic t_badsel;
    logic [31:0] d;
    int v0;
    mem[8] = w0(4'd9, 1'b0, 1'b1);
    v0 = valids;
    wr(9'h000, 32'h09);
    repeat (8) @(negedge clk);
    chk("R10 no valid", valids - v0, 0);
    rd(9'h008, d); chk("R10 head held", d, 32);
    rd(9'h000, d); chk("R10 run cleared", d, 32'h08);
    rd(9'h010, d); chk("R10 err and stopped", d, 6);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_regs;
    t_no_run;
    t_basic;
    t_wrap;
    t_soc;
    t_err;
    t_badsel;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule